// File: doc/BRIEF.md
# Tri-State Phase-Frequency Detector

This block compares the timing of two digital signals, a reference and a feedback signal taken from a loop oscillator, inside a fast synchronous clock domain. Both inputs are brought into the domain through synchronisers, and only their rising edges are used, so the duty cycle of either signal does not affect the result. The block drives a three-state error signal toward an external loop filter. The signal is driven high to speed the oscillator up, driven low to slow it down, or released to high impedance when neither correction is pending.

The three-state signal is carried as a data bit and an output-enable bit, which a pad or a downstream driver combines. A separate lock indication is high whenever the error signal is released. In a locked loop it stays high almost all the time, apart from short corrections at the edges.

Top module: `pfd_tristate_detector`

## Requirements
- R1: After a synchronous active-high reset, `err_oe` is 0, `err_data` is 0 and `lock_pulse` is 1.
- R2: From the released state, a reference rising edge with no feedback rising edge in the same cycle drives the output high: `err_oe`=1, `err_data`=1, `lock_pulse`=0.
- R3: While driven high, the output stays high until a feedback rising edge is detected. That edge releases the output (`err_oe`=0, `lock_pulse`=1).
- R4: From the released state, a feedback rising edge alone drives the output low (`err_oe`=1, `err_data`=0, `lock_pulse`=0). A later reference rising edge releases it.
- R5: Whenever `err_oe` is 0, `err_data` is 0 and `lock_pulse` is 1. Whenever `err_oe` is 1, `lock_pulse` is 0.
- R6: Falling edges on either input have no effect on the outputs.
- R7: When rising edges on both inputs are detected in the same clock cycle, the output is released, whatever the previous state.
- R8: While driven high, further reference rising edges have no effect. While driven low, further feedback rising edges have no effect.
- R9: With `SYNC_STAGES`=2 and `OUT_REG`=0, an input change set up before clock edge k shows on the outputs after edge k+2 and not earlier.
- R10: With no reference edges, repeated feedback edges keep the output driven low in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than either input |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference signal, asynchronous |
| fb_in | input | 1 | Feedback signal from the oscillator, asynchronous |
| err_data | output | 1 | Level of the error signal when driven; 0 when released |
| err_oe | output | 1 | 1 when the error signal is driven, 0 when it is high impedance |
| lock_pulse | output | 1 | High while the error signal is released |

## Verification
The bench builds the block with its defaults: two synchroniser stages and no output register. The input-to-output latency is then exactly three clock edges, and the bench samples at precisely that edge, one edge earlier, and everywhere in between. Under these values, back-to-back edges on one input, edges on both inputs that line up in the same cycle, and long runs of one-sided edges can all be placed cycle-exactly from directed stimulus.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic [1:0] {
        PD_RELEASED = 2'd0,
        PD_PUMP_UP  = 2'd1,
        PD_PUMP_DN  = 2'd2
    } pd_state_e;

    typedef struct packed {
        logic data;
        logic oe;
        logic lock;
    } pd_out_t;

    localparam pd_out_t PD_OUT_IDLE = '{data: 1'b0, oe: 1'b0, lock: 1'b1};

endpackage

// File: rtl/pfd_sync.sv
module pfd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_regs_t;

    sync_regs_t regs_d, regs_q;

    generate
        if (STAGES < 2) begin : g_bad_depth
            initial $error("pfd_sync: STAGES must be at least 2");
        end
    endgenerate

    always_comb begin
        regs_d       = regs_q;
        regs_d.chain = {regs_q.chain[STAGES-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q <= '0;
        else     regs_q <= regs_d;
    end

    assign dout = regs_q.chain[STAGES-1];

endmodule

// File: rtl/pfd_edge.sv
module pfd_edge (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic rise
);
    typedef struct packed {
        logic prev;
    } edge_regs_t;

    edge_regs_t regs_d, regs_q;

    always_comb begin
        regs_d      = regs_q;
        regs_d.prev = level;
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q <= '0;
        else     regs_q <= regs_d;
    end

    assign rise = level & ~regs_q.prev;

    AST_RISE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);                                        // R6

endmodule

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ref_rise,
    input  logic      fb_rise,
    output pd_state_e state
);
    typedef struct packed {
        pd_state_e st;
    } core_regs_t;

    core_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        unique case (regs_q.st)
            PD_RELEASED: begin
                if (ref_rise && !fb_rise)      regs_d.st = PD_PUMP_UP;
                else if (fb_rise && !ref_rise) regs_d.st = PD_PUMP_DN;
            end
            PD_PUMP_UP: begin
                if (fb_rise) regs_d.st = PD_RELEASED;
            end
            PD_PUMP_DN: begin
                if (ref_rise) regs_d.st = PD_RELEASED;
            end
            default: regs_d.st = PD_RELEASED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q <= '{st: PD_RELEASED};
        else     regs_q <= regs_d;
    end

    assign state = regs_q.st;

    AST_REF_STARTS_UP: assert property (@(posedge clk) disable iff (rst)
        (regs_q.st == PD_RELEASED && ref_rise && !fb_rise) |=> regs_q.st == PD_PUMP_UP); // R2
    AST_UP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (regs_q.st == PD_PUMP_UP && !fb_rise) |=> regs_q.st == PD_PUMP_UP);              // R8
    AST_UP_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (regs_q.st == PD_PUMP_UP && fb_rise) |=> regs_q.st == PD_RELEASED);              // R3
    AST_FB_STARTS_DN: assert property (@(posedge clk) disable iff (rst)
        (regs_q.st == PD_RELEASED && fb_rise && !ref_rise) |=> regs_q.st == PD_PUMP_DN); // R4
    AST_DN_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (regs_q.st == PD_PUMP_DN && !ref_rise) |=> regs_q.st == PD_PUMP_DN);             // R8
    AST_BOTH_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (ref_rise && fb_rise) |=> regs_q.st == PD_RELEASED);                             // R7
    AST_NO_DIRECT_SWAP: assert property (@(posedge clk) disable iff (rst)
        (regs_q.st == PD_PUMP_UP) |=> regs_q.st != PD_PUMP_DN);                          // R3

endmodule

// File: rtl/pfd_encode.sv
module pfd_encode
    import pfd_pkg::*;
#(
    parameter bit OUT_REG = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  pd_state_e state,
    output pd_out_t   out
);
    pd_out_t out_d;

    always_comb begin
        out_d = PD_OUT_IDLE;
        unique case (state)
            PD_PUMP_UP: out_d = '{data: 1'b1, oe: 1'b1, lock: 1'b0};
            PD_PUMP_DN: out_d = '{data: 1'b0, oe: 1'b1, lock: 1'b0};
            default:    out_d = PD_OUT_IDLE;
        endcase
    end

    generate
        if (OUT_REG) begin : g_registered
            pd_out_t out_q;
            always_ff @(posedge clk) begin
                if (rst) out_q <= PD_OUT_IDLE;
                else     out_q <= out_d;
            end
            assign out = out_q;
        end else begin : g_direct
            assign out = out_d;
        end
    endgenerate

endmodule

// File: rtl/pfd_tristate_detector.sv
module pfd_tristate_detector
    import pfd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter bit OUT_REG     = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_in,
    input  logic fb_in,
    output logic err_data,
    output logic err_oe,
    output logic lock_pulse
);
    localparam int NUM_CH = 2;
    localparam int CH_REF = 0;
    localparam int CH_FB  = 1;

    logic [NUM_CH-1:0] raw_in;
    logic [NUM_CH-1:0] synced;
    logic [NUM_CH-1:0] rises;
    pd_state_e         state;
    pd_out_t           enc;

    assign raw_in[CH_REF] = ref_in;
    assign raw_in[CH_FB]  = fb_in;

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
            pfd_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk  (clk),
                .rst  (rst),
                .din  (raw_in[ch]),
                .dout (synced[ch])
            );
            pfd_edge u_edge (
                .clk   (clk),
                .rst   (rst),
                .level (synced[ch]),
                .rise  (rises[ch])
            );
        end
    endgenerate

    pfd_core u_core (
        .clk      (clk),
        .rst      (rst),
        .ref_rise (rises[CH_REF]),
        .fb_rise  (rises[CH_FB]),
        .state    (state)
    );

    pfd_encode #(.OUT_REG(OUT_REG)) u_enc (
        .clk   (clk),
        .rst   (rst),
        .state (state),
        .out   (enc)
    );

    assign err_data   = enc.data;
    assign err_oe     = enc.oe;
    assign lock_pulse = enc.lock;

    AST_RELEASED_DATA_LOW: assert property (@(posedge clk) disable iff (rst)
        !err_oe |-> !err_data);                                 // R5
    AST_LOCK_TRACKS_RELEASE: assert property (@(posedge clk) disable iff (rst)
        lock_pulse == !err_oe);                                 // R5
    AST_FALL_NO_START: assert property (@(posedge clk) disable iff (rst)
        ($fell(synced[CH_REF]) && !rises[CH_FB] && state == PD_RELEASED)
            |=> state == PD_RELEASED);                          // R6

endmodule

// File: tb/pfd_tristate_detector_test.sv
module pfd_tristate_detector_test;
    localparam time CLK_PERIOD = 10ns;
    localparam int  LAT        = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_in = 1'b0;
    logic fb_in  = 1'b0;
    logic err_data, err_oe, lock_pulse;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pfd_tristate_detector uut (
        .clk        (clk),
        .rst        (rst),
        .ref_in     (ref_in),
        .fb_in      (fb_in),
        .err_data   (err_data),
        .err_oe     (err_oe),
        .lock_pulse (lock_pulse)
    );

    // expected mode: 0 released, 1 driven high, 2 driven low
    task automatic check_mode(input string tag, input int mode);
        logic e_oe, e_data, e_lock;
        e_oe   = (mode != 0);
        e_data = (mode == 1);
        e_lock = (mode == 0);
        checks++;
        if (err_oe !== e_oe || err_data !== e_data || lock_pulse !== e_lock) begin
            errors++;
            $display("FAIL %s: got oe=%b data=%b lock=%b expected oe=%b data=%b lock=%b",
                     tag, err_oe, err_data, lock_pulse, e_oe, e_data, e_lock);
        end
    endtask

    task automatic drive(input logic r, input logic f);
        @(negedge clk);
        ref_in = r;
        fb_in  = f;
    endtask

    task automatic settle();
        repeat (LAT) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_mode("R1 reset state", 0);
        check_mode("R5 released encoding", 0);
    endtask

    task automatic t_ref_leads();
        drive(1'b1, 1'b0);
        repeat (LAT-1) @(posedge clk);
        @(negedge clk);
        check_mode("R9 no change before latency", 0);
        @(posedge clk);
        @(negedge clk);
        check_mode("R2 reference first drives high", 1);
        drive(1'b0, 1'b0);
        settle();
        check_mode("R6 reference fall ignored", 1);
        drive(1'b0, 1'b1);
        settle();
        check_mode("R3 feedback edge releases", 0);
        drive(1'b0, 1'b0);
        settle();
        check_mode("R6 feedback fall ignored", 0);
    endtask

    task automatic t_fb_leads();
        drive(1'b0, 1'b1);
        settle();
        check_mode("R4 feedback first drives low", 2);
        drive(1'b0, 1'b0);
        settle();
        drive(1'b0, 1'b1);
        settle();
        check_mode("R8 extra feedback edge while low", 2);
        drive(1'b1, 1'b1);
        settle();
        check_mode("R4 reference edge releases", 0);
        drive(1'b0, 1'b0);
        settle();
    endtask

    task automatic t_up_extra();
        drive(1'b1, 1'b0);
        settle();
        drive(1'b0, 1'b0);
        settle();
        drive(1'b1, 1'b0);
        settle();
        check_mode("R8 extra reference edge while high", 1);
        drive(1'b1, 1'b1);
        settle();
        check_mode("R3 release after repeated reference", 0);
        drive(1'b0, 1'b0);
        settle();
    endtask

    task automatic t_simultaneous();
        drive(1'b1, 1'b1);
        settle();
        check_mode("R7 coincident edges from released", 0);
        drive(1'b0, 1'b0);
        settle();
        drive(1'b1, 1'b0);
        settle();
        drive(1'b0, 1'b0);
        settle();
        check_mode("R2 high before coincident edges", 1);
        drive(1'b1, 1'b1);
        settle();
        check_mode("R7 coincident edges from high", 0);
        drive(1'b0, 1'b0);
        settle();
    endtask

    task automatic t_no_reference();
        drive(1'b0, 1'b1);
        settle();
        for (int p = 0; p < 6; p++) begin
            @(negedge clk);
            fb_in = 1'b0;
            for (int c = 0; c < 4; c++) begin
                @(negedge clk);
                check_mode("R10 low held without reference", 2);
            end
            fb_in = 1'b1;
            for (int c = 0; c < 4; c++) begin
                @(negedge clk);
                check_mode("R10 low held without reference", 2);
            end
        end
        drive(1'b1, 1'b1);
        settle();
        check_mode("R4 reference finally releases", 0);
        drive(1'b0, 1'b0);
        settle();
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_ref_leads();
        t_fb_leads();
        t_up_extra();
        t_simultaneous();
        t_no_reference();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule